// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received Ethernet frame is kept, using only its 48-bit destination address. It first compares the address against a small table of station addresses. Each table entry has its own valid flag. If no valid entry matches, it forms a 12-bit hash from the last two address bytes at a bit offset chosen by software. The hash picks one bit of a 4096-bit multicast table, and that bit decides whether the frame is kept.

Software loads the station entries, the multicast table and the hash offset through a single write port. The write port has a 2-bit space select, an index and a 32-bit data word. The receive path presents an address with a one-cycle request. One cycle later the block returns a valid pulse with the accept flag. It also keeps a saturating count of frames accepted through the multicast table.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, every station entry, every valid flag, every multicast table bit, the hash mode and the hit counter are zero, so every lookup is rejected until software configures the block.
- R2: The lookup address carries byte k in bits [8k+7:8k]. A station entry is loaded in two writes. Space 0 writes the low word, which holds bytes 0 to 3 with byte 0 in bits [7:0]. Space 1 writes bytes 4 and 5 in bits [15:0] and the valid flag in bit 31. A lookup whose address equals a valid entry is accepted, and the hit counter is left unchanged.
- R3: An entry whose valid flag is 0 never causes a match, even when its stored address equals the lookup address.
- R4: When no entry matches, a 16-bit value is taken from lookupAddr[47:32]. It is shifted right by 4, 3, 2 or 0 for hash modes 0, 1, 2 and 3, and its low 12 bits form the hash. Hash bits [11:5] select one of the 128 multicast words, and bits [4:0] select the bit within that word. Space 2 writes the word named by the index, and space 3 sets the mode from data bits [1:0].
- R5: If the selected multicast bit is 1, the lookup is accepted and the hit counter increases by one. If the bit is 0, the lookup is rejected and the counter is unchanged.
- R6: The hit counter stops at its all-ones value and never wraps.
- R7: resultValid is 1 exactly in the cycle after a cycle with lookupReq high, and 0 otherwise. resultAccept is 0 whenever resultValid is 0.
- R8: A write made in the same cycle as a lookup does not affect that lookup. It affects the next lookup.
- R9: A station write (space 0 or 1) whose index is 16 or more is ignored and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSpace | input | 2 | Write target: 0 station low word, 1 station high word, 2 multicast word, 3 hash mode |
| cfgIdx | input | 8 | Station entry or multicast word index |
| cfgData | input | 32 | Write data |
| lookupReq | input | 1 | Lookup request strobe |
| lookupAddr | input | 48 | Destination address, byte 0 in bits [7:0] |
| resultValid | output | 1 | Result pulse, one cycle after lookupReq |
| resultAccept | output | 1 | Frame accepted |
| mcastHitCount | output | CNT_W | Saturating count of multicast-table accepts |

## Verification
A corrupted station entry or valid flag shows up on resultAccept at the first lookup of that address, one cycle after the request. A wrong hash offset or table word first appears as a wrong accept on a multicast lookup, and in the same cycle as a wrong step of mcastHitCount. Because the counter only ever moves on multicast accepts, an exact match that leaks into the hash path is visible on the counter even when the accept flag is right. The bench compares all three outputs every cycle against a behavioural model. A bad entry therefore surfaces in the cycle right after the first lookup that reaches it.

// File: rtl/rx_filter_pkg.sv
package rx_filter_pkg;
  parameter int unsigned CFG_IDX_W  = 8;
  parameter int unsigned CFG_DATA_W = 32;
  parameter int unsigned ADDR_W     = 48;

  typedef enum logic [1:0] {
    SP_STA_LO = 2'd0,
    SP_STA_HI = 2'd1,
    SP_MCAST  = 2'd2,
    SP_MODE   = 2'd3
  } cfgSpace_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                  lookupGo;
    logic                  staLoWr;
    logic                  staHiWr;
    logic                  mcastWr;
    logic                  modeWr;
    logic [CFG_IDX_W-1:0]  idx;
    logic [CFG_DATA_W-1:0] data;
  } cfgStrobe_t;
endpackage

// File: rtl/rx_filter_ctrl.sv
module rx_filter_ctrl
  import rx_filter_pkg::*;
#(
  parameter int unsigned NUM_STA  = 16,
  parameter int unsigned MT_WORDS = 128
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic [1:0]            cfgSpace,
  input  logic [CFG_IDX_W-1:0]  cfgIdx,
  input  logic [CFG_DATA_W-1:0] cfgData,
  input  logic                  lookupReq,
  output cfgStrobe_t            strb
);
  logic staIdxOk;
  logic mcIdxOk;

  assign staIdxOk = (32'(cfgIdx) < NUM_STA);
  assign mcIdxOk  = (32'(cfgIdx) < MT_WORDS);

  always_comb begin
    strb          = '0;
    strb.lookupGo = lookupReq;
    strb.idx      = cfgIdx;
    strb.data     = cfgData;
    if (cfgWrEn) begin
      case (cfgSpace)
        SP_STA_LO: strb.staLoWr = staIdxOk;
        SP_STA_HI: strb.staHiWr = staIdxOk;
        SP_MCAST:  strb.mcastWr = mcIdxOk;
        default:   strb.modeWr  = 1'b1;
      endcase
    end
  end

  // R9
  write_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.staLoWr, strb.staHiWr, strb.mcastWr, strb.modeWr}));

  // R9
  sta_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.staLoWr || strb.staHiWr) |-> (32'(strb.idx) < NUM_STA));
endmodule

// File: rtl/rx_filter_datapath.sv
module rx_filter_datapath
  import rx_filter_pkg::*;
#(
  parameter int unsigned NUM_STA = 16,
  parameter int unsigned HASH_W  = 12,
  parameter int unsigned CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strb,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              resultValid,
  output logic              resultAccept,
  output logic [CNT_W-1:0]  mcastHitCount
);
  localparam int unsigned BIT_SEL_W  = 5;
  localparam int unsigned WORD_BITS  = 2 ** BIT_SEL_W;
  localparam int unsigned WORD_SEL_W = HASH_W - BIT_SEL_W;
  localparam int unsigned MT_WORDS   = 2 ** WORD_SEL_W;
  localparam int unsigned HI_W       = ADDR_W - 32;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [31:0]          staLo    [NUM_STA];
  logic [HI_W-1:0]      staHi    [NUM_STA];
  logic [NUM_STA-1:0]   staValid;
  logic [WORD_BITS-1:0] mcTable  [MT_WORDS];
  logic [1:0]           hashMode;

  // station table storage
  for (genvar i = 0; i < NUM_STA; i++) begin : g_sta
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        staLo[i]    <= '0;
        staHi[i]    <= '0;
        staValid[i] <= 1'b0;
      end else begin
        if (strb.staLoWr && (strb.idx == CFG_IDX_W'(i)))
          staLo[i] <= strb.data[31:0];
        if (strb.staHiWr && (strb.idx == CFG_IDX_W'(i))) begin
          staHi[i]    <= strb.data[HI_W-1:0];
          staValid[i] <= strb.data[31];
        end
      end
    end
  end

  // multicast table storage
  for (genvar w = 0; w < MT_WORDS; w++) begin : g_mt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        mcTable[w] <= '0;
      else if (strb.mcastWr && (strb.idx == CFG_IDX_W'(w)))
        mcTable[w] <= strb.data[WORD_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            hashMode <= 2'd0;
    else if (strb.modeWr) hashMode <= strb.data[1:0];
  end

  // exact compare against every valid entry
  logic [NUM_STA-1:0] hitVec;
  logic               exactHit;
  for (genvar i = 0; i < NUM_STA; i++) begin : g_cmp
    assign hitVec[i] = staValid[i] && ({staHi[i], staLo[i]} == lookupAddr);
  end
  assign exactHit = |hitVec;

  // hash from the top two address bytes
  logic [HI_W-1:0]       hashSrc;
  logic [HI_W-1:0]       hashShifted;
  logic [HASH_W-1:0]     hashIdx;
  logic [WORD_SEL_W-1:0] wordSel;
  logic [BIT_SEL_W-1:0]  bitSel;
  logic                  mcBit;

  assign hashSrc = lookupAddr[ADDR_W-1:32];
  always_comb begin
    case (hashMode)
      2'd0:    hashShifted = hashSrc >> 4;
      2'd1:    hashShifted = hashSrc >> 3;
      2'd2:    hashShifted = hashSrc >> 2;
      default: hashShifted = hashSrc;
    endcase
  end
  assign hashIdx = hashShifted[HASH_W-1:0];
  assign wordSel = hashIdx[HASH_W-1:BIT_SEL_W];
  assign bitSel  = hashIdx[BIT_SEL_W-1:0];
  assign mcBit   = mcTable[wordSel][bitSel];

  // registered result and saturating counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultValid   <= 1'b0;
      resultAccept  <= 1'b0;
      mcastHitCount <= '0;
    end else begin
      resultValid  <= strb.lookupGo;
      resultAccept <= strb.lookupGo && (exactHit || mcBit);
      if (strb.lookupGo && !exactHit && mcBit && (mcastHitCount != CNT_MAX))
        mcastHitCount <= mcastHitCount + 1'b1;
    end
  end

  // R7
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.lookupGo |=> resultValid);
  // R7
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lookupGo |=> !resultValid);
  // R7
  accept_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultAccept |-> resultValid);
  // R6
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mcastHitCount == CNT_MAX) |=> (mcastHitCount == CNT_MAX));
  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mcastHitCount != $past(mcastHitCount)) |->
      (resultAccept && (mcastHitCount == CNT_W'($past(mcastHitCount) + 1'b1))));
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rx_filter_pkg::*;
#(
  parameter int unsigned NUM_STA = 16,
  parameter int unsigned HASH_W  = 12,
  parameter int unsigned CNT_W   = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic [1:0]            cfgSpace,
  input  logic [CFG_IDX_W-1:0]  cfgIdx,
  input  logic [CFG_DATA_W-1:0] cfgData,
  input  logic                  lookupReq,
  input  logic [ADDR_W-1:0]     lookupAddr,
  output logic                  resultValid,
  output logic                  resultAccept,
  output logic [CNT_W-1:0]      mcastHitCount
);
  localparam int unsigned MT_WORDS = 2 ** (HASH_W - 5);

  cfgStrobe_t strb;

  rx_filter_ctrl #(
    .NUM_STA (NUM_STA),
    .MT_WORDS(MT_WORDS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgSpace (cfgSpace),
    .cfgIdx   (cfgIdx),
    .cfgData  (cfgData),
    .lookupReq(lookupReq),
    .strb     (strb)
  );

  rx_filter_datapath #(
    .NUM_STA(NUM_STA),
    .HASH_W (HASH_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .lookupAddr   (lookupAddr),
    .resultValid  (resultValid),
    .resultAccept (resultAccept),
    .mcastHitCount(mcastHitCount)
  );
endmodule

// File: tb/tb_rx_dest_filter.sv
`timescale 1ns/1ps
module tb_rx_dest_filter;
  localparam int CW    = 4;
  localparam int CMAX  = (1 << CW) - 1;
  localparam int NSTA  = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSpace = 2'd0;
  logic [7:0]  cfgIdx = 8'd0;
  logic [31:0] cfgData = 32'd0;
  logic        lookupReq = 1'b0;
  logic [47:0] lookupAddr = 48'd0;
  logic        resultValid, resultAccept;
  logic [CW-1:0] mcastHitCount;

  always #2.5 clk = ~clk;

  rx_dest_filter #(.CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSpace(cfgSpace),
    .cfgIdx(cfgIdx), .cfgData(cfgData), .lookupReq(lookupReq),
    .lookupAddr(lookupAddr), .resultValid(resultValid),
    .resultAccept(resultAccept), .mcastHitCount(mcastHitCount)
  );

  int nChecks = 0;
  int nFails  = 0;

  // behavioural reference state
  logic [31:0] mLo [NSTA];
  logic [31:0] mHi [NSTA];
  bit          mBits [4096];
  int          mMode = 0;
  int          mCnt  = 0;

  function automatic int hashOf(input logic [47:0] a, input int mode);
    int sh;
    int v;
    sh = (mode == 0) ? 4 : (mode == 1) ? 3 : (mode == 2) ? 2 : 0;
    v  = int'(a[47:40]) * 256 + int'(a[39:32]);
    return (v >> sh) % 4096;
  endfunction

  function automatic bit modelLookup(input logic [47:0] a, output bit viaMc);
    bit hit;
    hit   = 0;
    viaMc = 0;
    for (int i = 0; i < NSTA; i++)
      if (mHi[i][31] && (mHi[i][15:0] == a[47:32]) && (mLo[i] == a[31:0])) hit = 1;
    if (!hit) begin
      viaMc = mBits[hashOf(a, mMode)];
      hit   = viaMc;
    end
    return hit;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at a falling edge, compare at the next falling edge
  task automatic cycle(input bit we, input int sp, input int idx, input logic [31:0] dat,
                       input bit req, input logic [47:0] addr, input string tag);
    bit expAcc;
    bit viaMc;
    cfgWrEn = we; cfgSpace = 2'(sp); cfgIdx = 8'(idx); cfgData = dat;
    lookupReq = req; lookupAddr = addr;
    expAcc = 0;
    if (req) begin
      expAcc = modelLookup(addr, viaMc);
      if (viaMc && mCnt < CMAX) mCnt++;
    end
    if (we) begin
      case (sp)
        0: if (idx < NSTA) mLo[idx] = dat;
        1: if (idx < NSTA) mHi[idx] = dat;
        2: if (idx < 128) for (int k = 0; k < 32; k++) mBits[idx*32 + k] = dat[k];
        default: mMode = int'(dat[1:0]);
      endcase
    end
    @(negedge clk);
    check("R7", int'(resultValid), int'(req));
    check(tag, int'(resultAccept), int'(expAcc));
    check("R5/R6 counter", int'(mcastHitCount), mCnt);
  endtask

  task automatic idle();
    cycle(0, 0, 0, 0, 0, 48'd0, "R7");
  endtask

  task automatic wr(input int sp, input int idx, input logic [31:0] dat);
    cycle(1, sp, idx, dat, 0, 48'd0, "R7");
  endtask

  task automatic look(input logic [47:0] a, input string tag);
    cycle(0, 0, 0, 0, 1, a, tag);
  endtask

  initial begin
    #1000000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [47:0] addrA, addrB, addrC, addrD, addrE;
    int h;
    for (int i = 0; i < NSTA; i++) begin mLo[i] = 0; mHi[i] = 0; end
    for (int i = 0; i < 4096; i++) mBits[i] = 0;
    addrA = 48'h5544_3322_1100;
    addrB = 48'h0B0A_0908_0706;
    addrC = 48'hABCD_0000_0001;
    addrD = 48'h1357_2468_ACE0;
    addrE = 48'h7777_6666_5555;

    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(resultValid), 0);
    check("R1 reset count", int'(mcastHitCount), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: nothing configured, all rejected
    look(addrA, "R1");
    look(48'hFFFF_FFFF_FFFF, "R1");
    look(48'h0, "R1");
    idle();

    // R2: exact match on a valid entry
    wr(0, 3, addrA[31:0]);
    wr(1, 3, {1'b1, 15'd0, addrA[47:32]});
    look(addrA, "R2");
    idle();
    // R3: stored but not valid
    wr(0, 5, addrB[31:0]);
    wr(1, 5, {1'b0, 15'd0, addrB[47:32]});
    look(addrB, "R3");
    // R9: out-of-range station index ignored
    wr(0, 19, addrE[31:0]);
    wr(1, 19, {1'b1, 15'd0, addrE[47:32]});
    look(addrE, "R9");
    look(addrA, "R9 entry 3 intact");

    // R4: each hash mode
    for (int m = 0; m < 4; m++) begin
      wr(3, 0, 32'(m));
      h = hashOf(addrC, m);
      look(addrC, "R4 before set");
      wr(2, h / 32, 32'd1 << (h % 32));
      look(addrC, "R4");
      look(addrC ^ 48'h0100_0000_0000, "R4 other hash");
      wr(2, h / 32, 32'd0);
      look(addrC, "R4 cleared");
    end

    // R2: exact match has priority, counter untouched
    wr(3, 0, 32'd0);
    h = hashOf(addrA, 0);
    wr(2, h / 32, 32'd1 << (h % 32));
    look(addrA, "R2 priority");

    // R8: write in same cycle as lookup
    cycle(1, 0, 7, addrD[31:0], 0, 48'd0, "R8");
    cycle(1, 1, 7, {1'b1, 15'd0, addrD[47:32]}, 1, addrD, "R8 same cycle");
    look(addrD, "R8 next lookup");
    cycle(1, 1, 7, 32'd0, 1, addrD, "R8 invalidate same cycle");
    look(addrD, "R8 after invalidate");

    // R6: saturation
    wr(3, 0, 32'd1);
    h = hashOf(addrC, 1);
    wr(2, h / 32, 32'hFFFF_FFFF);
    for (int n = 0; n < 20; n++) look(addrC, "R6");
    idle();

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      bit we;
      bit rq;
      int sp;
      int idx;
      logic [31:0] dat;
      logic [47:0] a;
      int pick;
      we  = ($urandom % 3) == 0;
      rq  = ($urandom % 4) != 0;
      sp  = $urandom % 4;
      idx = (sp == 2) ? ($urandom % 128) : ($urandom % 20);
      dat = $urandom;
      if (sp == 1) dat[30:16] = 15'd0;
      pick = $urandom % NSTA;
      if ($urandom % 2) a = {mHi[pick][15:0], mLo[pick]};
      else              a = {16'($urandom), 32'($urandom)};
      cycle(we, sp, idx, dat, rq, a, "R2/R4/R5 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule